// File: doc/BRIEF.md
# Circular Operand Stack Buffer with Background Spill and Fill

The block holds the upper part of an operand stack in a small register file that is used as a ring. A top-of-stack pointer picks the newest entry, and the three newest entries are always presented to the pipeline as read operands. Each cycle the pipeline may remove up to three entries and push one result. Together these express the usual stack operations: a binary operation pops two and pushes one, a load pushes, and a store pops.

A stack manager runs alongside the pipeline through ports of its own. It watches how many entries are live. When the ring gets close to full, it copies the deepest live entry out to a word-wide memory port. When the ring gets close to empty and earlier entries are held in memory, it brings the most recently saved word back in underneath the deepest entry. Saved words sit at a memory stack pointer, so they come back in the reverse order of their departure. The pipeline sees one continuous stack. It is held off, through a stall output, only when an operation asks for more entries than are present or would push past the ring's capacity.

Top module: `sc_stack_cache`

## Requirements
- R1: After reset the occupancy output is 0, no memory request is active, and the stall output is low while no operation is requested.
- R2: The operand outputs show the entries at TOS, TOS-1 and TOS-2 (slot indices modulo the depth) combinationally. A pushed value appears at the first operand output in the cycle after the clock edge that accepts it.
- R3: An accepted operation removes pop_cnt_i entries (0 to 3) and then places push_data_i on top when push_i is set. On-chip occupancy plus words saved in memory always equals the logical stack depth.
- R4: An operation whose pop_cnt_i exceeds the current occupancy stalls, and it changes neither the stack contents nor the pointer.
- R5: A push that would make occupancy, plus a fill still in flight, exceed the depth (64) stalls. Occupancy never exceeds the depth.
- R6: With no request active and occupancy at or above the spill mark (56), the next cycle starts a write request. The write carries the deepest live entry, and its address equals the number of words already saved. On-chip occupancy drops by one when the request starts.
- R7: With no request active, occupancy at or below the fill mark (8), and at least one saved word, the next cycle starts a read request at address (saved words - 1). On acknowledge the word is placed below the deepest entry and occupancy rises by one.
- R8: Words written to memory and read back restore the stack in last-in, first-out order, so values match the logical stack at every depth.
- R9: A request holds its address, direction and write data unchanged until the cycle in which mem_ack_i is seen high. Only one request is outstanding at a time.
- R10: Spill takes priority over fill, and no read request starts while no words are saved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Push push_data_i after the pops of this cycle |
| push_data_i | input | 32 | Value to push |
| pop_cnt_i | input | 2 | Number of entries to remove this cycle (0..3) |
| opa_o | output | 32 | Entry at TOS |
| opb_o | output | 32 | Entry at TOS-1 |
| opc_o | output | 32 | Entry at TOS-2 |
| stall_o | output | 1 | Requested operation cannot be accepted this cycle |
| occ_o | output | 7 | Number of live on-chip entries (0..64) |
| mem_req_o | output | 1 | Memory request active |
| mem_we_o | output | 1 | 1 = write (spill), 0 = read (fill) |
| mem_addr_o | output | 8 | Memory word address |
| mem_wdata_o | output | 32 | Spill data |
| mem_ack_i | input | 1 | Memory acknowledge, one cycle |
| mem_rdata_i | input | 32 | Fill data, valid with mem_ack_i |

## Verification
Stall and the three operands are combinational, so they are checked in the same cycle as the request, at the falling edge. A pushed or popped result is checked one edge after acceptance. A spill or fill request is due one edge after the negedge at which its trigger was seen with the manager idle. Its occupancy effect comes at that same edge for spill and at the edge after acknowledge for fill. The memory model acknowledges a set number of cycles after a request. It counts saved words at the edge that consumes the acknowledge, so the conservation check adds one for a write still in flight. Every comparison waits for the falling edge after the register it depends on has updated.

// File: rtl/sc_pkg.sv
package sc_pkg;
  typedef enum logic [1:0] {
    MGR_IDLE  = 2'd0,
    MGR_SPILL = 2'd1,
    MGR_FILL  = 2'd2
  } mgr_state_e;
endpackage

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int DEPTH = 64,
  parameter int DW    = 32,
  parameter int NRD   = 3,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic                    clk_i,
  input  logic                    cw_en_i,
  input  logic [PW-1:0]           cw_addr_i,
  input  logic [DW-1:0]           cw_data_i,
  input  logic                    fw_en_i,
  input  logic [PW-1:0]           fw_addr_i,
  input  logic [DW-1:0]           fw_data_i,
  input  logic [NRD-1:0][PW-1:0]  rd_addr_i,
  output logic [NRD-1:0][DW-1:0]  rd_data_o,
  input  logic [PW-1:0]           sp_addr_i,
  output logic [DW-1:0]           sp_data_o
);
  logic [DW-1:0] slot_q [DEPTH];

  // compute write is issued last so it wins a shared slot
  always_ff @(posedge clk_i) begin
    if (fw_en_i) slot_q[fw_addr_i] <= fw_data_i;
    if (cw_en_i) slot_q[cw_addr_i] <= cw_data_i;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd_data_o[g] = slot_q[rd_addr_i[g]];
  end

  assign sp_data_o = slot_q[sp_addr_i];
endmodule

// File: rtl/sc_ptr.sv
module sc_ptr #(
  parameter int DEPTH = 64,
  localparam int PW   = $clog2(DEPTH),
  localparam int OW   = PW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [1:0]    pop_cnt_i,
  input  logic          spill_issue_i,
  input  logic          fill_ack_i,
  input  logic          fill_pend_i,
  output logic          stall_o,
  output logic [PW-1:0] tos_o,
  output logic [OW-1:0] occ_o,
  output logic          cw_en_o,
  output logic [PW-1:0] cw_addr_o,
  output logic [PW-1:0] bot_addr_o,
  output logic [PW-1:0] fill_addr_o
);
  logic [PW-1:0] tos_q, tos_d;
  logic [OW-1:0] occ_q, occ_d;
  logic [OW:0]   occ_x, after_pop, need, occ_sum;
  logic          pop_bad, push_bad, go;

  always_comb begin
    occ_x     = {1'b0, occ_q};
    pop_bad   = (OW+1)'(pop_cnt_i) > occ_x;
    after_pop = occ_x - (OW+1)'(pop_cnt_i);
    need      = after_pop + (OW+1)'(push_i) + (OW+1)'(fill_pend_i);
    push_bad  = push_i && (need > (OW+1)'(DEPTH));
    go        = !(pop_bad || push_bad);

    tos_d   = tos_q;
    occ_sum = occ_x;
    if (go) begin
      tos_d   = tos_q - PW'(pop_cnt_i) + PW'(push_i);
      occ_sum = after_pop + (OW+1)'(push_i);
    end
    occ_sum = occ_sum - (OW+1)'(spill_issue_i) + (OW+1)'(fill_ack_i);
    occ_d   = occ_sum[OW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tos_q <= PW'(DEPTH - 1);
      occ_q <= '0;
    end else begin
      tos_q <= tos_d;
      occ_q <= occ_d;
    end
  end

  assign stall_o     = !go;
  assign tos_o       = tos_q;
  assign occ_o       = occ_q;
  assign cw_en_o     = go && push_i;
  assign cw_addr_o   = tos_q - PW'(pop_cnt_i) + PW'(1);
  assign bot_addr_o  = tos_q - occ_q[PW-1:0] + PW'(1);
  assign fill_addr_o = tos_q - occ_q[PW-1:0];
endmodule

// File: rtl/sc_mgr.sv
module sc_mgr
  import sc_pkg::*;
#(
  parameter int DW      = 32,
  parameter int OW      = 7,
  parameter int MEM_AW  = 8,
  parameter int SPILL_HI = 56,
  parameter int FILL_LO  = 8,
  localparam int MEM_WORDS = 1 << MEM_AW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OW-1:0]     occ_i,
  input  logic [DW-1:0]     bot_data_i,
  output logic              spill_issue_o,
  output logic              fill_ack_o,
  output logic              fill_pend_o,
  output logic [DW-1:0]     fill_data_o,
  output logic              spill_room_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  output logic [DW-1:0]     mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DW-1:0]     mem_rdata_i
);
  mgr_state_e        state_q;
  logic [MEM_AW:0]   msp_q;
  logic [MEM_AW-1:0] addr_q;
  logic [DW-1:0]     wdata_q;
  logic              spill_go, fill_go, idle;

  assign idle         = (state_q == MGR_IDLE);
  assign spill_room_o = msp_q < (MEM_AW+1)'(MEM_WORDS);
  assign spill_go     = idle && (occ_i >= OW'(SPILL_HI)) && spill_room_o;
  assign fill_go      = idle && !spill_go && (occ_i <= OW'(FILL_LO)) && (msp_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= MGR_IDLE;
      msp_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      unique case (state_q)
        MGR_IDLE: begin
          if (spill_go) begin
            state_q <= MGR_SPILL;
            addr_q  <= msp_q[MEM_AW-1:0];
            wdata_q <= bot_data_i;
            msp_q   <= msp_q + 1'b1;
          end else if (fill_go) begin
            state_q <= MGR_FILL;
            addr_q  <= MEM_AW'(msp_q - 1'b1);
            msp_q   <= msp_q - 1'b1;
          end
        end
        MGR_SPILL, MGR_FILL: if (mem_ack_i) state_q <= MGR_IDLE;
        default: state_q <= MGR_IDLE;
      endcase
    end
  end

  assign spill_issue_o = spill_go;
  assign fill_pend_o   = (state_q == MGR_FILL);
  assign fill_ack_o    = fill_pend_o && mem_ack_i;
  assign fill_data_o   = mem_rdata_i;
  assign mem_req_o     = !idle;
  assign mem_we_o      = (state_q == MGR_SPILL);
  assign mem_addr_o    = addr_q;
  assign mem_wdata_o   = wdata_q;
endmodule

// File: rtl/sc_stack_cache.sv
module sc_stack_cache #(
  parameter int DEPTH    = 64,
  parameter int DW       = 32,
  parameter int MEM_AW   = 8,
  parameter int SPILL_HI = 56,
  parameter int FILL_LO  = 8,
  localparam int PW      = $clog2(DEPTH),
  localparam int OW      = PW + 1,
  localparam int NRD     = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DW-1:0]     push_data_i,
  input  logic [1:0]        pop_cnt_i,
  output logic [DW-1:0]     opa_o,
  output logic [DW-1:0]     opb_o,
  output logic [DW-1:0]     opc_o,
  output logic              stall_o,
  output logic [OW-1:0]     occ_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  output logic [DW-1:0]     mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DW-1:0]     mem_rdata_i
);
  logic [PW-1:0]          tos, cw_addr, bot_addr, fill_addr;
  logic                   cw_en, spill_issue, fill_ack, fill_pend, spill_room;
  logic [DW-1:0]          bot_data, fill_data;
  logic [NRD-1:0][PW-1:0] rd_addr;
  logic [NRD-1:0][DW-1:0] rd_data;

  sc_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk_i, .rst_ni, .push_i, .pop_cnt_i,
    .spill_issue_i (spill_issue),
    .fill_ack_i    (fill_ack),
    .fill_pend_i   (fill_pend),
    .stall_o,
    .tos_o         (tos),
    .occ_o,
    .cw_en_o       (cw_en),
    .cw_addr_o     (cw_addr),
    .bot_addr_o    (bot_addr),
    .fill_addr_o   (fill_addr)
  );

  for (genvar g = 0; g < NRD; g++) begin : g_ra
    assign rd_addr[g] = tos - PW'(g);
  end

  sc_regfile #(.DEPTH(DEPTH), .DW(DW), .NRD(NRD)) u_rf (
    .clk_i,
    .cw_en_i   (cw_en),
    .cw_addr_i (cw_addr),
    .cw_data_i (push_data_i),
    .fw_en_i   (fill_ack),
    .fw_addr_i (fill_addr),
    .fw_data_i (fill_data),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data),
    .sp_addr_i (bot_addr),
    .sp_data_o (bot_data)
  );

  sc_mgr #(
    .DW(DW), .OW(OW), .MEM_AW(MEM_AW), .SPILL_HI(SPILL_HI), .FILL_LO(FILL_LO)
  ) u_mgr (
    .clk_i, .rst_ni,
    .occ_i         (occ_o),
    .bot_data_i    (bot_data),
    .spill_issue_o (spill_issue),
    .fill_ack_o    (fill_ack),
    .fill_pend_o   (fill_pend),
    .fill_data_o   (fill_data),
    .spill_room_o  (spill_room),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o,
    .mem_ack_i, .mem_rdata_i
  );

  assign opa_o = rd_data[0];
  assign opb_o = rd_data[1];
  assign opc_o = rd_data[2];
endmodule

// File: rtl/sc_stack_cache_chk.sv
module sc_stack_cache_chk #(
  parameter int DEPTH    = 64,
  parameter int DW       = 32,
  parameter int MEM_AW   = 8,
  parameter int SPILL_HI = 56,
  parameter int FILL_LO  = 8,
  parameter int OW       = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              push_i,
  input logic [1:0]        pop_cnt_i,
  input logic              stall_o,
  input logic [OW-1:0]     occ_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [MEM_AW-1:0] mem_addr_o,
  input logic [DW-1:0]     mem_wdata_o,
  input logic              mem_ack_i,
  input logic              spill_room
);
  a_r9_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_we_o) &&
                                $stable(mem_addr_o) && $stable(mem_wdata_o));

  a_r5_occ_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(occ_o) <= DEPTH);

  a_r4_underflow_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(pop_cnt_i) > int'(occ_o) |-> stall_o);

  a_r5_full_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && pop_cnt_i == 2'd0 && int'(occ_o) == DEPTH |-> stall_o);

  a_r6_spill_trigger: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o) && mem_we_o |-> int'($past(occ_o)) >= SPILL_HI);

  a_r7_fill_trigger: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o) && !mem_we_o |-> int'($past(occ_o)) <= FILL_LO);

  a_r6_spill_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_req_o && int'(occ_o) >= SPILL_HI && spill_room |=> mem_req_o && mem_we_o);

  a_r3_occ_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (int'(occ_o) <= int'($past(occ_o)) + 2) &&
             (int'(occ_o) + 4 >= int'($past(occ_o))));
endmodule

bind sc_stack_cache sc_stack_cache_chk #(
  .DEPTH(DEPTH), .DW(DW), .MEM_AW(MEM_AW),
  .SPILL_HI(SPILL_HI), .FILL_LO(FILL_LO), .OW(OW)
) u_chk (
  .clk_i, .rst_ni, .push_i, .pop_cnt_i, .stall_o, .occ_o,
  .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_ack_i,
  .spill_room (spill_room)
);

// File: tb/tb_sc_stack_cache.sv
module tb_sc_stack_cache;
  localparam int DEPTH = 64;
  localparam int HI    = 56;
  localparam int LO    = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        push_i = 1'b0;
  logic [31:0] push_data_i = '0;
  logic [1:0]  pop_cnt_i = '0;
  logic [31:0] opa_o, opb_o, opc_o, mem_wdata_o;
  logic        stall_o, mem_req_o, mem_we_o;
  logic [6:0]  occ_o;
  logic [7:0]  mem_addr_o;
  logic        mem_ack_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;

  always #4 clk_i = ~clk_i;

  sc_stack_cache dut (.*);

  int n_chk = 0, n_fail = 0;
  logic [31:0] ref_q [1024];
  int dep = 0;
  logic [31:0] mem_m [256];
  int words = 0, lat = 0, wait_c = 0;
  bit exp_spill = 0, exp_fill = 0, exp_none = 0, hold_pend = 0;
  logic [7:0] hold_addr;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] dv(int i);
    return (32'(i) * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction

  // memory model: ack after lat+1 cycles, update at the edge that consumes ack
  always @(posedge clk_i) begin
    if (mem_ack_i) begin
      mem_ack_i <= 1'b0;
      if (mem_we_o) begin
        chk(int'(mem_addr_o) == words, "R8 spill addr", mem_addr_o, words);
        chk(mem_wdata_o == ref_q[words], "R8 spill data", mem_wdata_o, ref_q[words]);
        mem_m[mem_addr_o] = mem_wdata_o;
        words++;
      end else begin
        words--;
      end
    end else if (mem_req_o) begin
      if (wait_c >= lat) begin
        mem_ack_i   <= 1'b1;
        mem_rdata_i <= mem_m[mem_addr_o];
        wait_c      <= 0;
      end else wait_c <= wait_c + 1;
    end
  end

  task automatic cycle(input bit push, input logic [31:0] d, input int pop);
    bit xs;
    int occ, fp;
    push_i = push; push_data_i = d; pop_cnt_i = 2'(pop);
    @(negedge clk_i);
    occ = int'(occ_o);
    fp  = (mem_req_o && !mem_we_o) ? 1 : 0;
    xs  = (pop > occ) || (push && (occ - pop + 1 + fp > DEPTH));
    if (pop > occ) chk(stall_o == xs, "R4 stall", stall_o, xs);
    else           chk(stall_o == xs, "R5 stall", stall_o, xs);
    if (occ >= 1) chk(opa_o == ref_q[dep-1], "R2 opa", opa_o, ref_q[dep-1]);
    if (occ >= 2) chk(opb_o == ref_q[dep-2], "R2 opb", opb_o, ref_q[dep-2]);
    if (occ >= 3) chk(opc_o == ref_q[dep-3], "R2 opc", opc_o, ref_q[dep-3]);
    chk(occ + words + ((mem_req_o && mem_we_o) ? 1 : 0) == dep, "R3 depth", occ, dep);
    chk(occ <= DEPTH, "R5 bound", occ, DEPTH);
    if (exp_spill) begin
      chk(mem_req_o && mem_we_o, "R6 spill req", {mem_req_o, mem_we_o}, 2'b11);
      chk(int'(mem_addr_o) == words, "R6 spill addr", mem_addr_o, words);
    end
    if (exp_fill) begin
      chk(mem_req_o && !mem_we_o, "R7 fill req", {mem_req_o, mem_we_o}, 2'b10);
      chk(int'(mem_addr_o) == words - 1, "R7 fill addr", mem_addr_o, words - 1);
    end
    if (exp_none) chk(!mem_req_o, "R10 no fill", mem_req_o, 0);
    if (hold_pend) chk(mem_req_o && mem_addr_o == hold_addr, "R9 hold", mem_addr_o, hold_addr);
    exp_spill = !mem_req_o && occ >= HI;
    exp_fill  = !mem_req_o && occ <= LO && words > 0;
    exp_none  = !mem_req_o && occ <= LO && words == 0;
    hold_pend = mem_req_o && !mem_ack_i;
    hold_addr = mem_addr_o;
    @(posedge clk_i);
    if (!xs) begin
      dep -= pop;
      if (push) begin ref_q[dep] = d; dep++; end
    end
    #1;
  endtask

  initial begin
    int k;
    k = 0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(occ_o == 0, "R1 occ", occ_o, 0);
    chk(!stall_o, "R1 stall", stall_o, 0);
    chk(!mem_req_o, "R1 req", mem_req_o, 0);
    @(posedge clk_i); #1;

    // R4: pops at empty
    cycle(1'b0, '0, 1);
    cycle(1'b1, dv(k++), 2);

    // R6: fast memory, deep push run
    lat = 0;
    for (int i = 0; i < 80; i++) cycle(1'b1, dv(k++), 0);
    // R5: slow memory, ring fills up and pushes stall
    lat = 12;
    for (int i = 0; i < 60; i++) cycle(1'b1, dv(k++), 0);
    cycle(1'b1, dv(k++), 1);
    // R3: mixed pop counts with push/replace
    lat = 2;
    for (int i = 0; i < 200; i++) cycle(i % 3 != 0, dv(k++), i % 4);
    // R7/R8: drain through fills
    lat = 1;
    for (int i = 0; i < 3000 && dep > 0; i++) cycle(1'b0, '0, 2);
    for (int i = 0; i < 20 && dep > 0; i++) cycle(1'b0, '0, 1);
    // R10: empty with nothing saved
    cycle(1'b0, '0, 1);
    cycle(1'b0, '0, 0);
    cycle(1'b1, dv(k++), 0);
    cycle(1'b1, dv(k++), 1);
    cycle(1'b0, '0, 3);
    cycle(1'b0, '0, 1);
    cycle(1'b0, '0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired actual=hang expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule